// File: doc/BRIEF.md
# Nibble-Wide Accumulator Processor Core

This block is a compact 4-bit processor. It reads its program one nibble at a time through a request/acknowledge memory port and runs a 16-opcode instruction set. Most opcodes are two nibbles long. Opcodes 0xC to 0xF are three nibbles long. The visible state is a 4-bit accumulator, a 7-bit program counter, two 7-bit index registers (X and Y), a carry flag and a 4-entry return-address stack.

Memory operands are not addressed directly. An operand nibble picks X or Y and adds a 3-bit offset to it. The port reaches two 128-nibble spaces: a program space and a data space. A separate memory-interface block answers each request. It may hold off the acknowledge for any number of cycles, and the core keeps its request steady until the acknowledge arrives.

Top module: `nib_cpu`

## Requirements
- R1: While `rst_n` is low, `mem_req` is 0. After release, the first request is a program-space read of address 0, and A, X, Y, carry and every stack entry start at 0.
- R2: A transfer takes place in a cycle where `mem_req` and `mem_ack` are both 1. While a request waits for its acknowledge, `mem_addr`, `mem_data_sp`, `mem_we` and `mem_wdata` do not change. Once out of reset, the core requests in every cycle.
- R3: Instruction nibbles are read from program space (`mem_data_sp`=0, `mem_we`=0) at the PC, and the PC steps by 1 modulo 128 after each one. Opcodes 0x0–0xB take one operand nibble and opcodes 0xC–0xF take two.
- R4: Opcodes 0x0 to 0x4 combine A with the program-space nibble at the indexed address: 0 add, 1 subtract, 2 OR, 3 AND, 4 XOR. The indexed address is (V[3] ? Y : X) + V[2:0], wrapping modulo 128. Add sets carry to the carry out of bit 3. Subtract sets carry to 1 exactly when A >= operand. OR, AND and XOR leave carry unchanged.
- R5: Opcode 0x5 loads A from the indexed address in program space. Opcode 0x6 loads A from the indexed address in data space (`mem_data_sp`=1).
- R6: Opcode 0xA writes A to the indexed address in data space. Opcode 0xB writes A to the indexed address in program space. Both assert `mem_we` and put A on `mem_wdata`.
- R7: Opcode 0x7 runs the sub-operation given by its second nibble. 0 swaps X and Y. 1 sets A to A+carry. 2 replaces X[3:0] with A. 3 returns. 4 sets Y to Y+A. 5 sets X to X+A. 6 sets Y to Y+1. 7 sets X to X+1. 8 to F do nothing. Index sums wrap modulo 128, and none of these changes carry.
- R8: Opcode 0x8 loads its immediate nibble into A. Opcode 0x9 adds its immediate nibble to A modulo 16 and leaves carry unchanged.
- R9: Opcode 0xC with nibbles H and L sets X to {H[2:0], L}.
- R10: Opcodes 0xD and 0xE with nibbles H and L go to {H[2:0], L} based on a tested value. The tested value is carry when H[3]=1 and (A != 0) when H[3]=0. 0xD jumps when the tested value is true and 0xE jumps when it is false. Otherwise execution continues at the next instruction.
- R11: Opcode 0xF goes to {H[2:0], L}. When H[3]=1 it is a call that first pushes the address of the next instruction. A push onto a full 4-entry stack discards the oldest entry. A return pops the newest entry, and a return from an empty stack goes to address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mem_req | output | 1 | A memory transfer is requested |
| mem_ack | input | 1 | The memory block completes the transfer in this cycle |
| mem_addr | output | 7 | Nibble address |
| mem_data_sp | output | 1 | 1 selects data space, 0 selects program space |
| mem_we | output | 1 | 1 for a write, 0 for a read |
| mem_wdata | output | 4 | Write data (the accumulator) |
| mem_rdata | input | 4 | Read data, valid in the acknowledge cycle |

## Verification
The return stack is the hardest state to reach from the ports. Its overflow and underflow edges only show up in the address of a later fetch. That fetch comes after a chain of at least five nested calls, followed by more returns than the stack holds. A directed program builds exactly that chain, nested five deep, and then unwinds it until the last return falls back to address 0. Seeded random program and data images, served with random acknowledge delays, then cover the rest. They reach carry-tested branches, index wraparound and code that rewrites itself. Every transfer is compared against a bench instruction model that tracks the same memory image.

// File: rtl/nib_cpu_pkg.sv
package nib_cpu_pkg;

  typedef enum logic [1:0] {
    PH_OPC = 2'd0,
    PH_ARG = 2'd1,
    PH_LOW = 2'd2,
    PH_MEM = 2'd3
  } phase_e;

  typedef enum logic [3:0] {
    OP_ADD = 4'h0, OP_SUB = 4'h1, OP_OR  = 4'h2, OP_AND = 4'h3,
    OP_XOR = 4'h4, OP_LDP = 4'h5, OP_LDD = 4'h6, OP_GRP = 4'h7,
    OP_LDI = 4'h8, OP_ADI = 4'h9, OP_STD = 4'hA, OP_STP = 4'hB,
    OP_LDX = 4'hC, OP_JNZ = 4'hD, OP_JZ  = 4'hE, OP_JMP = 4'hF
  } opc_e;

  localparam logic [3:0] G_SWAP = 4'h0;
  localparam logic [3:0] G_ADC  = 4'h1;
  localparam logic [3:0] G_XLO  = 4'h2;
  localparam logic [3:0] G_RET  = 4'h3;
  localparam logic [3:0] G_ADDY = 4'h4;
  localparam logic [3:0] G_ADDX = 4'h5;
  localparam logic [3:0] G_INCY = 4'h6;
  localparam logic [3:0] G_INCX = 4'h7;

endpackage

// File: rtl/nib_cpu_rst_sync.sv
module nib_cpu_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sh_q[STAGES-1];

endmodule

// File: rtl/nib_cpu_alu.sv
module nib_cpu_alu
  import nib_cpu_pkg::*;
#(
  parameter int DW = 4
) (
  input  opc_e          op_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  output logic [DW-1:0] y_o,
  output logic          cy_o,
  output logic          cy_we_o
);

  logic [DW:0] sum;
  logic [DW:0] dif;

  always_comb begin
    sum     = {1'b0, a_i} + {1'b0, b_i};
    dif     = {1'b0, a_i} - {1'b0, b_i};
    y_o     = b_i;
    cy_o    = 1'b0;
    cy_we_o = 1'b0;
    case (op_i)
      OP_ADD: begin y_o = sum[DW-1:0]; cy_o = sum[DW];  cy_we_o = 1'b1; end
      OP_SUB: begin y_o = dif[DW-1:0]; cy_o = ~dif[DW]; cy_we_o = 1'b1; end
      OP_OR:  y_o = a_i | b_i;
      OP_AND: y_o = a_i & b_i;
      OP_XOR: y_o = a_i ^ b_i;
      OP_ADI: y_o = sum[DW-1:0];
      default: y_o = b_i;
    endcase
  end

endmodule

// File: rtl/nib_cpu_rstack.sv
module nib_cpu_rstack #(
  parameter int AW    = 7,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [AW-1:0] din_i,
  output logic [AW-1:0] top_o
);

  logic [DEPTH-1:0][AW-1:0] ent_q, ent_d;

  // push shifts toward the bottom (oldest falls off); pop shifts up with zero fill
  always_comb begin
    if (push_i)     ent_d = {ent_q[DEPTH-2:0], din_i};
    else if (pop_i) ent_d = {{AW{1'b0}}, ent_q[DEPTH-1:1]};
    else            ent_d = ent_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              ent_q <= '0;
    else if (push_i | pop_i) ent_q <= ent_d;
  end

  assign top_o = ent_q[0];

  for (genvar i = 1; i < DEPTH; i++) begin : g_chk
    // R11: a push moves each entry one level deeper
    p_push_shift_r11: assert property (@(posedge clk) disable iff (!rst_n)
      push_i |=> ent_q[i] == $past(ent_q[i-1]));
  end

  // R11: a pop leaves the deepest slot empty, so underflow yields 0
  p_pop_fill_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && !push_i) |=> ent_q[DEPTH-1] == '0);

endmodule

// File: rtl/nib_cpu.sv
module nib_cpu
  import nib_cpu_pkg::*;
#(
  parameter int DW          = 4,
  parameter int AW          = 7,
  parameter int OFS_W       = 3,
  parameter int STACK_DEPTH = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic          mem_req,
  input  logic          mem_ack,
  output logic [AW-1:0] mem_addr,
  output logic          mem_data_sp,
  output logic          mem_we,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata
);

  localparam int HI_W = AW - DW;

  logic          run_n;
  phase_e        ph_q, ph_d;
  opc_e          opc_q, opc_d;
  logic [DW-1:0] arg_q, arg_d;
  logic [AW-1:0] pc_q, pc_d;
  logic [AW-1:0] xr_q, xr_d;
  logic [AW-1:0] yr_q, yr_d;
  logic [DW-1:0] acc_q, acc_d;
  logic          cy_q, cy_d;

  logic          xfer;
  logic [AW-1:0] pc_inc;
  logic [AW-1:0] eff_addr;
  logic [AW-1:0] jmp_tgt;
  logic          jtest;
  logic [DW-1:0] alu_y;
  logic          alu_cy, alu_cy_we;
  logic          stk_push, stk_pop;
  logic [AW-1:0] stk_top;

  nib_cpu_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .arst_n(rst_n), .srst_n(run_n));

  nib_cpu_alu #(.DW(DW)) u_alu (
    .op_i(opc_q), .a_i(acc_q), .b_i(mem_rdata),
    .y_o(alu_y), .cy_o(alu_cy), .cy_we_o(alu_cy_we));

  nib_cpu_rstack #(.AW(AW), .DEPTH(STACK_DEPTH)) u_stk (
    .clk(clk), .rst_n(run_n), .push_i(stk_push), .pop_i(stk_pop),
    .din_i(pc_inc), .top_o(stk_top));

  assign xfer     = mem_req & mem_ack;
  assign pc_inc   = pc_q + AW'(1);
  assign eff_addr = (arg_q[OFS_W] ? yr_q : xr_q) + AW'(arg_q[OFS_W-1:0]);
  assign jmp_tgt  = {arg_q[HI_W-1:0], mem_rdata};
  assign jtest    = arg_q[DW-1] ? cy_q : (acc_q != '0);
  assign stk_push = xfer && (ph_q == PH_LOW) && (opc_q == OP_JMP) && arg_q[DW-1];
  assign stk_pop  = xfer && (ph_q == PH_ARG) && (opc_q == OP_GRP) && (mem_rdata == G_RET);

  // memory port
  assign mem_req     = run_n;
  assign mem_addr    = (ph_q == PH_MEM) ? eff_addr : pc_q;
  assign mem_data_sp = (ph_q == PH_MEM) && (opc_q == OP_LDD || opc_q == OP_STD);
  assign mem_we      = (ph_q == PH_MEM) && (opc_q == OP_STD || opc_q == OP_STP);
  assign mem_wdata   = acc_q;

  always_comb begin
    ph_d  = ph_q;
    opc_d = opc_q;
    arg_d = arg_q;
    pc_d  = pc_q;
    xr_d  = xr_q;
    yr_d  = yr_q;
    acc_d = acc_q;
    cy_d  = cy_q;
    if (xfer) begin
      case (ph_q)
        PH_OPC: begin
          opc_d = opc_e'(mem_rdata);
          pc_d  = pc_inc;
          ph_d  = PH_ARG;
        end
        PH_ARG: begin
          arg_d = mem_rdata;
          pc_d  = pc_inc;
          ph_d  = PH_OPC;
          case (opc_q)
            OP_LDX, OP_JNZ, OP_JZ, OP_JMP: ph_d = PH_LOW;
            OP_LDI, OP_ADI:                acc_d = alu_y;
            OP_GRP: begin
              case (mem_rdata)
                G_SWAP: begin xr_d = yr_q; yr_d = xr_q; end
                G_ADC:  acc_d = acc_q + DW'(cy_q);
                G_XLO:  xr_d = {xr_q[AW-1:DW], acc_q};
                G_RET:  pc_d = stk_top;
                G_ADDY: yr_d = yr_q + AW'(acc_q);
                G_ADDX: xr_d = xr_q + AW'(acc_q);
                G_INCY: yr_d = yr_q + AW'(1);
                G_INCX: xr_d = xr_q + AW'(1);
                default: ;
              endcase
            end
            default: ph_d = PH_MEM;
          endcase
        end
        PH_LOW: begin
          pc_d = pc_inc;
          ph_d = PH_OPC;
          case (opc_q)
            OP_LDX: xr_d = jmp_tgt;
            OP_JNZ: if (jtest)  pc_d = jmp_tgt;
            OP_JZ:  if (!jtest) pc_d = jmp_tgt;
            default: pc_d = jmp_tgt;
          endcase
        end
        default: begin
          ph_d = PH_OPC;
          if (opc_q <= OP_LDD) begin
            acc_d = alu_y;
            if (alu_cy_we) cy_d = alu_cy;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge run_n) begin
    if (!run_n) begin
      ph_q  <= PH_OPC;
      opc_q <= OP_ADD;
      arg_q <= '0;
      pc_q  <= '0;
      xr_q  <= '0;
      yr_q  <= '0;
      acc_q <= '0;
      cy_q  <= 1'b0;
    end else if (xfer) begin
      ph_q  <= ph_d;
      opc_q <= opc_d;
      arg_q <= arg_d;
      pc_q  <= pc_d;
      xr_q  <= xr_d;
      yr_q  <= yr_d;
      acc_q <= acc_d;
      cy_q  <= cy_d;
    end
  end

  // R1: no request while reset is held
  p_no_req_rst_r1: assert property (@(posedge clk)
    !rst_n |-> !mem_req);

  // R2: a waiting request keeps every attribute steady
  p_req_hold_r2: assert property (@(posedge clk) disable iff (!run_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                               && $stable(mem_data_sp) && $stable(mem_wdata)));

  // R3: instruction nibbles are program-space reads
  p_fetch_read_r3: assert property (@(posedge clk) disable iff (!run_n)
    (mem_req && ph_q != PH_MEM) |-> (!mem_we && !mem_data_sp));

  // R3: an opcode fetch advances the PC by one
  p_pc_step_r3: assert property (@(posedge clk) disable iff (!run_n)
    (xfer && ph_q == PH_OPC) |=> pc_q == $past(pc_q) + AW'(1));

  // R4: logic operations leave carry alone
  p_carry_keep_r4: assert property (@(posedge clk) disable iff (!run_n)
    (xfer && ph_q == PH_MEM && (opc_q == OP_OR || opc_q == OP_AND || opc_q == OP_XOR))
      |=> $stable(cy_q));

endmodule

// File: tb/sim_nib_cpu.sv
module sim_nib_cpu;

  localparam int CLK_NS = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mem_req, mem_ack, mem_data_sp, mem_we;
  logic [6:0] mem_addr;
  logic [3:0] mem_wdata, mem_rdata;

  logic [3:0] pm [128];
  logic [3:0] dm [128];

  int checks = 0, errors = 0;

  nib_cpu u0 (
    .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_ack(mem_ack),
    .mem_addr(mem_addr), .mem_data_sp(mem_data_sp), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata));

  always #(CLK_NS/2) clk = ~clk;

  always_comb mem_rdata = mem_data_sp ? dm[mem_addr] : pm[mem_addr];

  // reference machine state
  logic [3:0] m_a;
  logic [6:0] m_pc, m_x, m_y;
  logic       m_c;
  logic [6:0] m_stk [4];
  string      next_tag;

  // expected transfers of the current instruction
  logic [6:0] e_addr [4];
  logic       e_sp [4], e_we [4];
  logic [3:0] e_wd [4];
  string      e_tag [4];
  int         e_n, e_i;

  logic       run = 1'b0;
  int         wait_n = 0, stall = 0, instr_cnt = 0, cyc = 0;
  logic       wd_hit = 1'b0, hold_chk = 1'b0;
  logic [6:0] h_addr;
  logic       h_sp, h_we;
  logic [3:0] h_wd;

  function automatic logic [4:0] f_add(input logic [3:0] a, input logic [3:0] b);
    return {1'b0, a} + {1'b0, b};
  endfunction

  function automatic logic [6:0] f_target(input logic [3:0] h, input logic [3:0] l);
    return {h[2:0], l};
  endfunction

  task automatic check(input string tag, input logic ok, input string what);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s", tag, what);
    end
  endtask

  task automatic add_exp(input logic [6:0] a, input logic sp, input logic we,
                         input logic [3:0] wd, input string tag);
    e_addr[e_n] = a; e_sp[e_n] = sp; e_we[e_n] = we; e_wd[e_n] = wd; e_tag[e_n] = tag;
    e_n++;
  endtask

  task automatic model_reset();
    m_a = 0; m_pc = 0; m_x = 0; m_y = 0; m_c = 0;
    for (int i = 0; i < 4; i++) m_stk[i] = 0;
    next_tag = "R1";
    e_n = 0; e_i = 0;
  endtask

  task automatic model_instr();
    logic [3:0] op, v, l, b;
    logic [6:0] ea;
    logic [4:0] s;
    logic       t;
    e_n = 0; e_i = 0;
    op = pm[m_pc]; add_exp(m_pc, 0, 0, 0, next_tag); m_pc++;
    v  = pm[m_pc]; add_exp(m_pc, 0, 0, 0, "R3");     m_pc++;
    l  = 0;
    if (op >= 4'hC) begin l = pm[m_pc]; add_exp(m_pc, 0, 0, 0, "R3"); m_pc++; end
    ea = (v[3] ? m_y : m_x) + {4'b0, v[2:0]};
    case (op)
      4'h0, 4'h1, 4'h2, 4'h3, 4'h4: begin
        b = pm[ea]; add_exp(ea, 0, 0, 0, "R4");
        case (op)
          4'h0: begin s = f_add(m_a, b); m_a = s[3:0]; m_c = s[4]; end
          4'h1: begin m_c = (m_a >= b); m_a = m_a - b; end
          4'h2: m_a = m_a | b;
          4'h3: m_a = m_a & b;
          default: m_a = m_a ^ b;
        endcase
        next_tag = "R4";
      end
      4'h5: begin m_a = pm[ea]; add_exp(ea, 0, 0, 0, "R5"); next_tag = "R5"; end
      4'h6: begin m_a = dm[ea]; add_exp(ea, 1, 0, 0, "R5"); next_tag = "R5"; end
      4'hA: begin add_exp(ea, 1, 1, m_a, "R6"); next_tag = "R6"; end
      4'hB: begin add_exp(ea, 0, 1, m_a, "R6"); next_tag = "R6"; end
      4'h7: begin
        next_tag = "R7";
        case (v)
          4'h0: begin ea = m_x; m_x = m_y; m_y = ea; end
          4'h1: m_a = m_a + {3'b0, m_c};
          4'h2: m_x = {m_x[6:4], m_a};
          4'h3: begin
            m_pc = m_stk[0];
            m_stk[0] = m_stk[1]; m_stk[1] = m_stk[2]; m_stk[2] = m_stk[3]; m_stk[3] = 0;
            next_tag = "R11";
          end
          4'h4: m_y = m_y + {3'b0, m_a};
          4'h5: m_x = m_x + {3'b0, m_a};
          4'h6: m_y = m_y + 1;
          4'h7: m_x = m_x + 1;
          default: ;
        endcase
      end
      4'h8: begin m_a = v; next_tag = "R8"; end
      4'h9: begin s = f_add(m_a, v); m_a = s[3:0]; next_tag = "R8"; end
      4'hC: begin m_x = f_target(v, l); next_tag = "R9"; end
      4'hD, 4'hE: begin
        t = v[3] ? m_c : (m_a != 0);
        if ((op == 4'hD) == t) m_pc = f_target(v, l);
        next_tag = "R10";
      end
      default: begin
        if (v[3]) begin
          m_stk[3] = m_stk[2]; m_stk[2] = m_stk[1]; m_stk[1] = m_stk[0]; m_stk[0] = m_pc;
        end
        m_pc = f_target(v, l);
        next_tag = "R11";
      end
    endcase
  endtask

  // memory responder, samples away from the rising edge
  always @(negedge clk) begin
    cyc++;
    mem_ack = 1'b0;
    if (!run) begin
      hold_chk = 1'b0;
      if (!rst_n) check("R1", mem_req == 1'b0, $sformatf("req=%0b exp=0 in reset", mem_req));
    end else begin
      if (hold_chk)
        check("R2", mem_req && mem_addr == h_addr && mem_data_sp == h_sp && mem_we == h_we
                    && mem_wdata == h_wd,
              $sformatf("req=%0b addr=%0h sp=%0b we=%0b wd=%0h exp held addr=%0h sp=%0b we=%0b wd=%0h",
                        mem_req, mem_addr, mem_data_sp, mem_we, mem_wdata, h_addr, h_sp, h_we, h_wd));
      hold_chk = 1'b0;
      stall++;
      if (stall > 40) wd_hit = 1'b1;
      if (mem_req) begin
        if (wait_n > 0) begin
          wait_n--;
          hold_chk = 1'b1;
          h_addr = mem_addr; h_sp = mem_data_sp; h_we = mem_we; h_wd = mem_wdata;
        end else begin
          if (e_i == e_n) model_instr();
          check(e_tag[e_i],
                mem_addr == e_addr[e_i] && mem_data_sp == e_sp[e_i] && mem_we == e_we[e_i]
                && (!e_we[e_i] || mem_wdata == e_wd[e_i]),
                $sformatf("addr=%0h sp=%0b we=%0b wd=%0h exp addr=%0h sp=%0b we=%0b wd=%0h",
                          mem_addr, mem_data_sp, mem_we, mem_wdata,
                          e_addr[e_i], e_sp[e_i], e_we[e_i], e_wd[e_i]));
          if (e_we[e_i]) begin
            if (e_sp[e_i]) dm[e_addr[e_i]] = e_wd[e_i];
            else           pm[e_addr[e_i]] = e_wd[e_i];
          end
          e_i++;
          if (e_i == e_n) instr_cnt++;
          mem_ack = 1'b1;
          wait_n = $urandom % 3;
          stall = 0;
        end
      end
    end
    if (cyc > 190000) wd_hit = 1'b1;
  end

  task automatic put(input int a, input logic [3:0] n);
    pm[a] = n;
  endtask

  task automatic start(input int n_instr);
    rst_n = 1'b0;
    run = 1'b0;
    repeat (3) @(posedge clk);
    model_reset();
    wait_n = 0; stall = 0; instr_cnt = 0;
    @(negedge clk);
    rst_n = 1'b1;
    run = 1'b1;
    while (instr_cnt < n_instr && !wd_hit) @(posedge clk);
  endtask

  initial begin
    void'($urandom(32'h5eed));
    // directed: immediates, X load, store, add, then five nested calls
    for (int i = 0; i < 128; i++) begin pm[i] = 0; dm[i] = 0; end
    put(0, 4'h8); put(1, 4'h5);                      // A=5
    put(2, 4'h9); put(3, 4'hC);                      // A=1 (wraps)
    put(4, 4'hC); put(5, 4'h1); put(6, 4'h0);        // X=0x10
    put(7, 4'hB); put(8, 4'h0);                      // pm[0x10]=A
    put(9, 4'h0); put(10, 4'h0);                     // A+=pm[0x10]
    put(11, 4'hF); put(12, 4'hA); put(13, 4'h0);     // call 0x20
    put(32, 4'hF); put(33, 4'hA); put(34, 4'h8);     // call 0x28
    put(35, 4'h7); put(36, 4'h3);
    put(40, 4'hF); put(41, 4'hB); put(42, 4'h0);     // call 0x30
    put(43, 4'h7); put(44, 4'h3);
    put(48, 4'hF); put(49, 4'hB); put(50, 4'h8);     // call 0x38
    put(51, 4'h7); put(52, 4'h3);
    put(56, 4'hF); put(57, 4'hC); put(58, 4'h0);     // call 0x40 (overflow)
    put(59, 4'h7); put(60, 4'h3);
    put(64, 4'h7); put(65, 4'h3);                    // unwinding; last ret pops 0
    start(40);
    // random program and data images, including carry-tested branches
    for (int ph = 0; ph < 4 && !wd_hit; ph++) begin
      for (int i = 0; i < 128; i++) begin
        pm[i] = 4'($urandom);
        dm[i] = 4'($urandom);
      end
      start(400);
    end
    run = 1'b0;
    if (wd_hit) begin
      checks++; errors++;
      $display("FAIL watchdog: no completion, exp progress");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule